// File: doc/BRIEF.md
# Output compare match flag unit

This block watches a timer count and compares it with a programmable compare value on every cycle. The raw equality result goes straight out as a match strobe, which a downstream waveform generator uses. A sticky compare flag records the match one timer tick later. When its enable is set, the flag raises an interrupt request.

The flag stays set until it is cleared. It clears when the interrupt controller acknowledges service, or when software writes a one to the flag. Writing a zero does nothing. The timer advances only on cycles where the tick strobe is high. The flag logic treats each count value as one match opportunity, so a counter that stalls on the matching value does not set the flag again after it has been cleared.

Top module: `ocmp_flag`

## Requirements
- R1: `match` is 1 exactly when `count` equals the stored compare value, combinationally in the same cycle.
- R2: A clock edge with `cmp_we` high loads `cmp_wdata` into the compare value. `match` reflects the new value from the cycle after that edge.
- R3: A tick edge is a clock edge with `tick` high. A tick edge is qualifying when, at that edge, `count` equals the compare value and `count` differs from the count seen at the previous tick edge (or no tick edge has happened since reset). The flag becomes 1 at the next tick edge after a qualifying tick edge, not at the qualifying edge itself.
- R4: The flag never goes from 0 to 1 on a clock edge where `tick` is low, however many cycles pass.
- R5: `irq` equals `flag` AND `irq_en` at all times.
- R6: A clock edge with `irq_ack` high clears the flag.
- R7: A clock edge with `flag_we` high and `flag_wdata` = 1 clears the flag. With `flag_wdata` = 0, the write leaves the flag unchanged.
- R8: When a set (R3) and a clear (R6 or R7) fall on the same edge, the flag ends up 1.
- R9: Repeated tick edges with `count` held at the matching value qualify only once. After that flag is cleared, it stays 0 until the count changes and matches again.
- R10: After reset, the compare value is 0, `flag` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer-clock enable strobe |
| count | input | CNT_W | Current timer count |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (1 clears, 0 ignored) |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt service acknowledge pulse |
| match | output | 1 | Raw equality strobe to waveform generator |
| flag | output | 1 | Compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 16-bit count width. The directed cases place the compare value at arbitrary points of that full range. The random phase instead keeps the compare value and the count inside a small window of low values. That way, matches, stalls on the matching value and collisions between set and clear happen often, within a few thousand cycles rather than once per 65536 counts.

// File: rtl/ocmp_flag.sv
module ocmp_flag #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_we,
  input  logic             flag_wdata,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             match,
  output logic             flag,
  output logic             irq
);

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] last_cnt;
  logic             seen;
  logic             hit;
  logic             fresh;
  logic             set_ev;
  logic             clr_ev;

  assign match  = (count == cmp_q);
  assign fresh  = !seen || (count != last_cnt);
  assign set_ev = tick && hit;
  assign clr_ev = irq_ack || (flag_we && flag_wdata);
  assign irq    = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_we) begin
      cmp_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cnt <= '0;
      seen     <= 1'b0;
      hit      <= 1'b0;
    end else if (tick) begin
      last_cnt <= count;
      seen     <= 1'b1;
      hit      <= match && fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_ev) begin
      flag <= 1'b1;
    end else if (clr_ev) begin
      flag <= 1'b0;
    end
  end

endmodule

module ocmp_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic flag_we,
  input logic flag_wdata,
  input logic irq_en,
  input logic irq_ack,
  input logic flag,
  input logic irq
);

  // R5
  a_r5_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flag && irq_en));

  // R4
  a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag) |=> !flag);

  // R3
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  // R6
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !tick) |=> !flag);

  // R7
  a_r7_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_wdata && !tick) |=> !flag);

  // R7
  a_r7_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_we && !flag_wdata && !irq_ack) |=> flag);

endmodule

bind ocmp_flag ocmp_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .flag_we(flag_we),
  .flag_wdata(flag_wdata), .irq_en(irq_en), .irq_ack(irq_ack),
  .flag(flag), .irq(irq)
);

// File: tb/ocmp_flag_test.sv
module ocmp_flag_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] count = '0;
  logic         cmp_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         flag_we = 1'b0;
  logic         flag_wdata = 1'b0;
  logic         irq_en = 1'b0;
  logic         irq_ack = 1'b0;
  logic         match, flag, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_cmp = '0;
  logic [W-1:0] m_prev = '0;
  logic         m_seen = 1'b0;
  logic         m_hit = 1'b0;
  logic         m_flag = 1'b0;

  always #2 clk = ~clk;

  ocmp_flag #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .irq_ack(irq_ack),
    .match(match), .flag(flag), .irq(irq)
  );

  function automatic logic exp_match(logic [W-1:0] c, logic [W-1:0] r);
    return c == r;
  endfunction

  function automatic logic exp_flag(logic f, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : f);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic set, clr;
    set = tick && m_hit;
    clr = irq_ack || (flag_we && flag_wdata);
    m_flag = exp_flag(m_flag, set, clr);
    if (tick) begin
      m_hit  = exp_match(count, m_cmp) && (!m_seen || count != m_prev);
      m_prev = count;
      m_seen = 1'b1;
    end
    if (cmp_we) m_cmp = cmp_wdata;
  endtask

  task automatic step(logic t, logic [W-1:0] c, logic cwe, logic [W-1:0] cwd,
                      logic fwe, logic fwd, logic en, logic ack);
    tick = t; count = c; cmp_we = cwe; cmp_wdata = cwd;
    flag_we = fwe; flag_wdata = fwd; irq_en = en; irq_ack = ack;
    #1;
    chk("R1", match, exp_match(count, m_cmp));
    chk("R5", irq, flag && irq_en);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3", flag, m_flag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rc;
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(negedge clk);
    chk("R10", flag, 1'b0);
    chk("R10", irq, 1'b0);
    chk("R10", match, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    step(0, 16'h0001, 1, 16'h1234, 0, 0, 1, 0);
    step(0, 16'h1234, 0, 0, 0, 0, 1, 0);
    chk("R2", match, 1'b1);
    step(1, 16'h1234, 0, 0, 0, 0, 1, 0);
    chk("R3", flag, 1'b0);
    repeat (4) step(0, 16'h1235, 0, 0, 0, 0, 1, 0);
    chk("R4", flag, 1'b0);
    step(1, 16'h1235, 0, 0, 0, 0, 1, 0);
    chk("R3", flag, 1'b1);
    chk("R5", irq, 1'b1);
    step(0, 16'h1235, 0, 0, 0, 0, 0, 0);
    chk("R5", irq, 1'b0);
    step(0, 16'h1235, 0, 0, 1, 0, 1, 0);
    chk("R7", flag, 1'b1);
    step(0, 16'h1235, 0, 0, 1, 1, 1, 0);
    chk("R7", flag, 1'b0);

    step(1, 16'h1234, 0, 0, 0, 0, 1, 0);
    step(1, 16'h1234, 0, 0, 0, 0, 1, 0);
    chk("R9", flag, 1'b1);
    step(0, 16'h1234, 0, 0, 0, 0, 1, 1);
    chk("R6", flag, 1'b0);
    repeat (5) step(1, 16'h1234, 0, 0, 0, 0, 1, 0);
    chk("R9", flag, 1'b0);

    step(1, 16'h1233, 0, 0, 0, 0, 1, 0);
    step(1, 16'h1234, 0, 0, 0, 0, 1, 0);
    step(1, 16'h1235, 0, 0, 0, 0, 1, 1);
    chk("R8", flag, 1'b1);
    step(0, 16'h1235, 0, 0, 1, 1, 1, 1);
    chk("R6", flag, 1'b0);

    step(0, 16'h0003, 1, 16'h0004, 0, 0, 1, 0);
    rc = 16'h0003;
    for (int i = 0; i < 4000; i++) begin
      logic t, cwe, fwe, fwd, en, ack;
      t   = ($urandom % 3) != 0;
      if (($urandom % 4) == 0) rc = (rc + 1) & 16'h0007;
      cwe = ($urandom % 40) == 0;
      fwe = ($urandom % 6) == 0;
      fwd = $urandom % 2;
      en  = ($urandom % 4) != 0;
      ack = ($urandom % 8) == 0;
      step(t, rc, cwe, 16'($urandom % 8), fwe, fwd, en, ack);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule